// File: doc/BRIEF.md
# Unaligned Write Splitter

This block sits between a requester that issues byte, halfword and word writes at any byte address and a 32-bit memory bus. The bus accepts only whole words, addresses words rather than bytes, and has no byte enables. The splitter breaks each incoming write into the bus transactions that the bus can carry.

A word write whose address has its two low bits at zero goes out as a single bus write. Any other write is done as a read-modify-write of each word it touches. The block reads the word, replaces only the byte lanes that the request covers, and writes the result back. A write that runs past the end of a word repeats this on the next word address, so a misaligned word write costs four bus transactions. The requester is held off until every transaction of its write has been acknowledged.

Top module: `unaligned_write_splitter`

## Requirements
- R1: After reset, `req_ready` is 1 and neither `mem_rd` nor `mem_wr` is asserted.
- R2: A write with `req_size` 2 and `req_addr[1:0]` = 0 produces exactly one bus write to word address `req_addr[ADDR_W-1:2]`, carrying `req_data` unchanged, and no bus read.
- R3: A write that stays inside one word without covering all of it produces one read followed by one write of that same word. The written value equals the read value with only the covered byte lanes replaced.
- R4: Byte ordering is little-endian. Byte i of `req_data` (bits 8i+7:8i) lands at byte position p = `req_addr[1:0]` + i. Position p < 4 is lane p of the first word, and lane k occupies bits 8k+7:8k. Position p >= 4 is lane p-4 of the next word.
- R5: A write whose bytes run past lane 3 produces four transactions in this order: read word A, write word A, read word A+1, write word A+1.
- R6: The second word address is the first word address plus one, taken modulo 2^(ADDR_W-2), so it wraps from all-ones to zero.
- R7: `req_size` encodes the width: 0 is one byte, 1 is two bytes, 2 is four bytes, and 3 is treated as four bytes. Bytes of `req_data` above the requested width are ignored.
- R8: The bus carries one transaction at a time. `mem_rd` and `mem_wr` are never asserted together, and an asserted strobe keeps its address and write data stable until the cycle in which `mem_ack` is seen.
- R9: `req_ready` is 0 from the cycle after a write is accepted until the last acknowledgement of that write, and is 1 again in the cycle after that acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Splitter idle; request taken when both valid and ready are high |
| req_addr | input | ADDR_W | Byte address of the write |
| req_size | input | 2 | Width code: 0 byte, 1 half, 2 or 3 word |
| req_data | input | 32 | Write data, least significant byte first |
| mem_addr | output | ADDR_W-2 | Word address on the memory bus |
| mem_rd | output | 1 | Bus read strobe |
| mem_wr | output | 1 | Bus write strobe |
| mem_wdata | output | 32 | Bus write data |
| mem_rdata | input | 32 | Bus read data, valid with mem_ack during a read |
| mem_ack | input | 1 | Bus acknowledge for the current strobe |

## Verification
The bench applies byte writes at each of the four offsets, halfwords both inside a word and straddling a boundary, and word writes at offsets zero, one and three. This separates the single-write path from the single-word and two-word read-modify-write paths, and it exposes any lane rotated by the wrong amount. A straddling word at the top of the address space shows whether the second address wraps. Size code 3 and junk in the unused upper data bytes show whether the width decoding is right. All of these are run with zero-wait and multi-wait acknowledgements, which shows whether the strobes hold their address and data until acknowledged.

// File: rtl/uws_pkg.sv
package uws_pkg;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned LANE_BITS  = 8;
    localparam int unsigned WORD_BITS  = WORD_BYTES * LANE_BITS;
    localparam int unsigned OFF_BITS   = $clog2(WORD_BYTES);

    typedef logic [WORD_BITS-1:0]  word_t;
    typedef logic [WORD_BYTES-1:0] lanes_t;
    typedef logic [OFF_BITS-1:0]   off_t;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD3 = 2'd3
    } wsize_e;

    // Lane-shifted image of one request across two adjacent words
    typedef struct packed {
        word_t  data_lo;
        lanes_t mask_lo;
        word_t  data_hi;
        lanes_t mask_hi;
        logic   spans;
        logic   whole;
    } plan_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_WR_A,
        ST_RD_B,
        ST_WR_B
    } seq_state_e;

    function automatic int size_bytes(wsize_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return int'(WORD_BYTES);
        endcase
    endfunction

    function automatic word_t merge_lanes(word_t old_w, word_t new_w, lanes_t m);
        word_t r;
        for (int k = 0; k < int'(WORD_BYTES); k++) begin
            r[k*LANE_BITS +: LANE_BITS] = m[k] ? new_w[k*LANE_BITS +: LANE_BITS]
                                               : old_w[k*LANE_BITS +: LANE_BITS];
        end
        return r;
    endfunction

endpackage

// File: rtl/uws_lane_shift.sv
module uws_lane_shift
    import uws_pkg::*;
(
    input  off_t                           off,
    input  wsize_e                         size,
    input  word_t                          data,
    output logic [2*WORD_BITS-1:0]         win_data,
    output logic [2*WORD_BYTES-1:0]        win_mask
);
    localparam int WIN_LANES = 2 * int'(WORD_BYTES);

    int nbytes;
    assign nbytes = size_bytes(size);

    // One selector per byte position of the two-word window
    for (genvar k = 0; k < WIN_LANES; k++) begin : g_pos
        logic [LANE_BITS-1:0] byte_v;
        logic                 hit;
        always_comb begin
            byte_v = '0;
            hit    = 1'b0;
            for (int i = 0; i < int'(WORD_BYTES); i++) begin
                if (i < nbytes && (int'(off) + i) == k) begin
                    byte_v = data[i*LANE_BITS +: LANE_BITS];
                    hit    = 1'b1;
                end
            end
        end
        assign win_data[k*LANE_BITS +: LANE_BITS] = byte_v;
        assign win_mask[k]                        = hit;
    end

endmodule

// File: rtl/uws_decode.sv
module uws_decode
    import uws_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]  addr,
    input  wsize_e             size,
    input  word_t              data,
    output plan_t              plan,
    output logic [ADDR_W-3:0]  wa_lo,
    output logic [ADDR_W-3:0]  wa_hi
);
    localparam int unsigned WA_W = ADDR_W - OFF_BITS;
    localparam logic [WA_W-1:0] WA_ONE = WA_W'(1);

    logic [2*WORD_BITS-1:0]  win_data;
    logic [2*WORD_BYTES-1:0] win_mask;

    uws_lane_shift u_shift (
        .off      (addr[OFF_BITS-1:0]),
        .size     (size),
        .data     (data),
        .win_data (win_data),
        .win_mask (win_mask)
    );

    always_comb begin
        plan.data_lo = win_data[WORD_BITS-1:0];
        plan.data_hi = win_data[2*WORD_BITS-1:WORD_BITS];
        plan.mask_lo = win_mask[WORD_BYTES-1:0];
        plan.mask_hi = win_mask[2*WORD_BYTES-1:WORD_BYTES];
        plan.spans   = |plan.mask_hi;
        plan.whole   = &plan.mask_lo;
    end

    assign wa_lo = addr[ADDR_W-1:OFF_BITS];
    assign wa_hi = wa_lo + WA_ONE;

endmodule

// File: rtl/uws_seq.sv
module uws_seq
    import uws_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic whole,
    input  logic spans,
    input  logic ack,
    output logic ready,
    output logic rd,
    output logic wr,
    output logic hi_phase
);
    seq_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (start) st_d = whole ? ST_WR_A : ST_RD_A;
            ST_RD_A: if (ack)   st_d = ST_WR_A;
            ST_WR_A: if (ack)   st_d = spans ? ST_RD_B : ST_IDLE;
            ST_RD_B: if (ack)   st_d = ST_WR_B;
            ST_WR_B: if (ack)   st_d = ST_IDLE;
            default:            st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign ready    = (st_q == ST_IDLE);
    assign rd       = (st_q == ST_RD_A) || (st_q == ST_RD_B);
    assign wr       = (st_q == ST_WR_A) || (st_q == ST_WR_B);
    assign hi_phase = (st_q == ST_RD_B) || (st_q == ST_WR_B);

    // R8: a pending read stays asserted until acknowledged
    p_rd_held_r8: assert property (@(posedge clk) disable iff (rst)
        (rd && !ack) |=> rd);

    // R8: a pending write stays asserted until acknowledged
    p_wr_held_r8: assert property (@(posedge clk) disable iff (rst)
        (wr && !ack) |=> wr);

    // R5: the second word is only visited after the first write completes
    p_second_after_first_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_phase) |-> $past(wr && ack));

endmodule

// File: rtl/unaligned_write_splitter.sv
module unaligned_write_splitter
    import uws_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_data,
    output logic [ADDR_W-3:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack
);
    localparam int unsigned WA_W = ADDR_W - OFF_BITS;
    localparam logic [WA_W-1:0] WA_ONE = WA_W'(1);

    plan_t           plan_d;
    logic [WA_W-1:0] wa_lo_d, wa_hi_d;

    word_t           data_lo_q, data_hi_q, wbuf_q, merged;
    lanes_t          mask_lo_q, mask_hi_q;
    logic            spans_q;
    logic [WA_W-1:0] wa_lo_q, wa_hi_q;
    logic            hi_phase, req_fire;

    uws_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr  (req_addr),
        .size  (wsize_e'(req_size)),
        .data  (req_data),
        .plan  (plan_d),
        .wa_lo (wa_lo_d),
        .wa_hi (wa_hi_d)
    );

    assign req_fire = req_valid && req_ready;

    uws_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (req_fire),
        .whole    (plan_d.whole),
        .spans    (spans_q),
        .ack      (mem_ack),
        .ready    (req_ready),
        .rd       (mem_rd),
        .wr       (mem_wr),
        .hi_phase (hi_phase)
    );

    assign merged = merge_lanes(mem_rdata,
                                hi_phase ? data_hi_q : data_lo_q,
                                hi_phase ? mask_hi_q : mask_lo_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_lo_q <= '0;
            data_hi_q <= '0;
            mask_lo_q <= '0;
            mask_hi_q <= '0;
            spans_q   <= 1'b0;
            wa_lo_q   <= '0;
            wa_hi_q   <= '0;
            wbuf_q    <= '0;
        end else if (req_fire) begin
            data_lo_q <= plan_d.data_lo;
            data_hi_q <= plan_d.data_hi;
            mask_lo_q <= plan_d.mask_lo;
            mask_hi_q <= plan_d.mask_hi;
            spans_q   <= plan_d.spans;
            wa_lo_q   <= wa_lo_d;
            wa_hi_q   <= wa_hi_d;
            wbuf_q    <= plan_d.data_lo;
        end else if (mem_rd && mem_ack) begin
            wbuf_q    <= merged;
        end
    end

    assign mem_addr  = hi_phase ? wa_hi_q : wa_lo_q;
    assign mem_wdata = wbuf_q;

    // R8: never a read and a write at once
    p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R8: address and data hold while a strobe waits
    p_bus_stable_r8: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_wdata)));

    // R9: requester held off while the bus is busy
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> !req_ready);

    // R2: an aligned full word goes straight to a write
    p_whole_no_read_r2: assert property (@(posedge clk) disable iff (rst)
        (req_fire && plan_d.whole) |=> (mem_wr && !mem_rd && mem_wdata == $past(req_data)));

    // R3: partial writes start with a read
    p_partial_reads_r3: assert property (@(posedge clk) disable iff (rst)
        (req_fire && !plan_d.whole) |=> mem_rd);

    // R6: the second word address is the first plus one
    p_next_word_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_ack && !hi_phase && spans_q) |=> (mem_rd && mem_addr == $past(mem_addr) + WA_ONE));

endmodule

// File: tb/unaligned_write_splitter_tb.sv
module unaligned_write_splitter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_data = '0;
    logic [29:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    unaligned_write_splitter #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_data(req_data),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Memory model with configurable wait states and a transaction log
    logic [31:0] mem_q [logic [29:0]];
    int          lat = 0;
    int          wcnt = 0;
    int          clash = 0;
    int          ready_busy = 0;
    int          unstable = 0;
    logic [29:0] hold_addr;
    logic [31:0] hold_data;
    bit          holding = 1'b0;
    bit          log_wr   [256];
    logic [29:0] log_addr [256];
    logic [31:0] log_data [256];
    int          log_n = 0;

    function automatic logic [31:0] peek(logic [29:0] a);
        if (mem_q.exists(a)) return mem_q[a];
        return {a[15:0] ^ 16'h3C5A, ~a[15:0]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            wcnt    = 0;
            holding = 1'b0;
        end else begin
            if (mem_rd && mem_wr) clash++;
            if ((mem_rd || mem_wr) && req_ready) ready_busy++;
            if ((mem_rd || mem_wr) && holding &&
                (mem_addr != hold_addr || (mem_wr && mem_wdata != hold_data))) unstable++;
            if (mem_ack) begin
                mem_ack <= 1'b0;
                holding = 1'b0;
            end else if (mem_rd || mem_wr) begin
                holding   = 1'b1;
                hold_addr = mem_addr;
                hold_data = mem_wdata;
                if (wcnt >= lat) begin
                    mem_ack <= 1'b1;
                    wcnt = 0;
                    log_wr[log_n % 256]   = mem_wr;
                    log_addr[log_n % 256] = mem_addr;
                    log_data[log_n % 256] = mem_wr ? mem_wdata : 32'h0;
                    log_n++;
                    if (mem_wr) mem_q[mem_addr] = mem_wdata;
                    else        mem_rdata <= peek(mem_addr);
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Issue one write and compare the logged bus traffic with the expectation
    task automatic run_write(input string req, input logic [31:0] addr,
                             input logic [1:0] size, input logic [31:0] data);
        int          nb, off, start, n_exp, waited;
        logic [29:0] wa0, wa1;
        logic [31:0] old0, old1, new0, new1;
        bit          e_wr   [4];
        logic [29:0] e_addr [4];
        logic [31:0] e_data [4];
        nb   = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
        off  = int'(addr[1:0]);
        wa0  = addr[31:2];
        wa1  = wa0 + 30'd1;
        old0 = peek(wa0);
        old1 = peek(wa1);
        new0 = old0;
        new1 = old1;
        for (int i = 0; i < nb; i++) begin
            int p;
            p = off + i;
            if (p < 4) new0[p*8 +: 8]     = data[i*8 +: 8];
            else       new1[(p-4)*8 +: 8] = data[i*8 +: 8];
        end
        if (off == 0 && nb == 4) begin
            n_exp = 1;
            e_wr[0] = 1'b1; e_addr[0] = wa0; e_data[0] = new0;
        end else begin
            n_exp = (off + nb > 4) ? 4 : 2;
            e_wr[0] = 1'b0; e_addr[0] = wa0; e_data[0] = 32'h0;
            e_wr[1] = 1'b1; e_addr[1] = wa0; e_data[1] = new0;
            e_wr[2] = 1'b0; e_addr[2] = wa1; e_data[2] = 32'h0;
            e_wr[3] = 1'b1; e_addr[3] = wa1; e_data[3] = new1;
        end

        start = log_n;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_size = size; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        req_data  = 32'hDEAD_BEEF;
        check("R9", {req, " ready low after accept"}, {31'd0, req_ready}, 32'd0);
        waited = 0;
        while (!req_ready && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        check(req, "transaction count", log_n - start, n_exp);
        if (log_n - start == n_exp) begin
            for (int j = 0; j < n_exp; j++) begin
                int idx;
                idx = (start + j) % 256;
                check(req, $sformatf("txn %0d kind", j), {31'd0, log_wr[idx]}, {31'd0, e_wr[j]});
                check(req, $sformatf("txn %0d addr", j), {2'd0, log_addr[idx]}, {2'd0, e_addr[j]});
                if (e_wr[j]) check(req, $sformatf("txn %0d data", j), log_data[idx], e_data[j]);
            end
        end
    endtask

    task automatic t_reset;
        check("R1", "ready after reset", {31'd0, req_ready}, 32'd1);
        check("R1", "rd after reset", {31'd0, mem_rd}, 32'd0);
        check("R1", "wr after reset", {31'd0, mem_wr}, 32'd0);
    endtask

    task automatic t_aligned;
        run_write("R2", 32'h0000_1008, 2'd2, 32'hCAFE_F00D);
        run_write("R2", 32'h0000_2000, 2'd2, 32'h1234_5678);
    endtask

    task automatic t_bytes;
        for (int o = 0; o < 4; o++)
            run_write("R3 R4", 32'h0000_3000 + o, 2'd0, 32'h0000_0091 + o);
        run_write("R3", 32'h0000_3101, 2'd1, 32'h0000_B7C8);
    endtask

    task automatic t_crossing;
        run_write("R5 R4", 32'h0000_1002, 2'd2, 32'hA1B2_C3D4);
        run_write("R5", 32'h0000_4003, 2'd2, 32'h0102_0304);
        run_write("R5", 32'h0000_4101, 2'd2, 32'h5566_7788);
        run_write("R5", 32'h0000_4203, 2'd1, 32'h0000_EE11);
    endtask

    task automatic t_wrap;
        run_write("R6", 32'hFFFF_FFFE, 2'd2, 32'h9988_7766);
    endtask

    task automatic t_sizes;
        run_write("R7", 32'h0000_5002, 2'd0, 32'hFFFF_FF42);
        run_write("R7", 32'h0000_5100, 2'd1, 32'hABCD_6655);
        run_write("R7", 32'h0000_5200, 2'd3, 32'h0BAD_F00D);
        run_write("R7", 32'h0000_5301, 2'd3, 32'h7654_3210);
    endtask

    task automatic t_bus_rules;
        check("R8", "strobes never together", clash, 0);
        check("R8", "addr/data held until ack", unstable, 0);
        check("R9", "ready low while bus busy", ready_busy, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        for (int l = 0; l < 3; l++) begin
            lat = (l == 0) ? 0 : (l == 1) ? 1 : 3;
            t_aligned();
            t_bytes();
            t_crossing();
            t_wrap();
            t_sizes();
        end
        t_bus_rules();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule